// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Capture

This block timestamps transitions on three external input pins. Each channel samples its pin through a two-stage synchronizer. A transition is accepted only when the new level has held for two consecutive clock edges. When the accepted transition matches the channel's edge selection, the channel copies the value of a shared free-running timer into a small FIFO. The FIFO holds two entries.

Software configures each channel through a 4-bit control field: an enable bit, a 2-bit edge selection and an interrupt enable. It reads timestamps by popping a channel's FIFO and watches a 2-bit fill code for each channel. A per-channel flag is raised on every capture and is cleared by writing one to it. A FIFO is emptied with a flush strobe. The timer is produced outside the block and only sampled here.

Top module: `cap_unit`

## Requirements
- R1: A pin change is captured only after the new level has been present at two consecutive rising edges. A pulse lasting one clock is ignored. With the pin changed between edges k-1 and k, the capture takes place at edge k+3.
- R2: Control bits [4i+2:4i+1] of `cfg_wdata` select the edges for channel i: 00 none, 01 rising, 10 falling, 11 both. Transitions that are not selected are not captured.
- R3: The stored value is the `timer_val` present at the capturing clock edge.
- R4: `rd_data` for a channel shows its oldest entry, or zero when the FIFO is empty. A pop moves the second entry forward. A pop on an empty FIFO has no effect. The fill code changes only on a capture, pop or flush.
- R5: `fill_lvl[2i+1:2i]` reads 0 when empty, 1 with one entry and 2 with two entries. A capture into a full FIFO discards the oldest entry, stores the new value and shows code 3.
- R6: A pop from code 3 leaves one entry and shows code 1.
- R7: `fifo_flush[i]` empties channel i and shows code 0 on the next cycle. A capture in the same cycle is discarded.
- R8: `cap_flag[i]` is set by each capture and stays set until a one is written to `flag_clr[i]`. A capture in the same cycle as a clear wins.
- R9: `irq` is the OR over channels of `cap_flag[i]` AND control bit [4i+3], the interrupt enable.
- R10: When control bit [4i] (enable) is 0, the channel captures nothing but keeps its FIFO contents, which remain readable and poppable.
- R11: Channels are independent. Activity on one channel does not alter another channel's fill code or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| timer_val | input | 16 | Shared free-running timer value |
| cap_pin | input | 3 | Asynchronous capture pins, one per channel |
| cfg_we | input | 1 | Load all control fields |
| cfg_wdata | input | 12 | 4 bits per channel: {irq_en, edge[1:0], enable} |
| rd_pop | input | 3 | Pop the oldest entry of a channel |
| fifo_flush | input | 3 | Empty a channel FIFO |
| flag_clr | input | 3 | Write-one-to-clear for capture flags |
| rd_data | output | 48 | Oldest entry per channel, 16 bits each |
| fill_lvl | output | 6 | 2-bit fill code per channel |
| cap_flag | output | 3 | Capture flags |
| irq | output | 1 | Combined masked interrupt |

## Verification
A capture, its FIFO entry, its flag and its fill code all become visible after the fourth rising edge that follows a pin change: two synchronizer stages, one qualification stage and the FIFO write. The bench therefore changes pins just after a falling edge. It checks one edge early, to confirm nothing has landed, and then once more after the fourth edge. Pops, flushes, flag clears and control writes take effect at the very next edge, so their results are sampled at the following falling edge. Each expected timestamp is the timer value the bench itself drove at the pin change, plus three.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int CTRL_W = 4;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // bit 3 irq enable, bits 2:1 edge selection, bit 0 channel enable
  typedef struct packed {
    logic      irq_en;
    edge_sel_e edge_sel;
    logic      enable;
  } ch_ctrl_t;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_ONE   = 2'd1,
    FILL_TWO   = 2'd2,
    FILL_OVF   = 2'd3
  } fill_e;

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    return (rise && sel[0]) || (fall && sel[1]);
  endfunction

  function automatic fill_e fill_code(logic [1:0] cnt, logic ovf);
    if (cnt == 2'd2 && ovf) return FILL_OVF;
    return fill_e'(cnt);
  endfunction

endpackage

// File: rtl/cap_sync_qual.sv
module cap_sync_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3 && s2 != lvl_q) lvl_q <= s2;
    end
  end

  assign rise = s2 && s3 && !lvl_q;
  assign fall = !s2 && !s3 && lvl_q;
endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic [1:0]   cnt,
  output logic         ovf
);
  logic [W-1:0] e0_q, e1_q;
  logic [1:0]   cnt_q;
  logic         ovf_q;
  logic         pop_ok;

  assign pop_ok = pop && (cnt_q != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0_q  <= '0;
      e1_q  <= '0;
      cnt_q <= 2'd0;
      ovf_q <= 1'b0;
    end else if (flush) begin
      cnt_q <= 2'd0;
      ovf_q <= 1'b0;
    end else begin
      case ({push, pop_ok})
        2'b10: begin
          case (cnt_q)
            2'd0: begin e0_q <= push_data; cnt_q <= 2'd1; end
            2'd1: begin e1_q <= push_data; cnt_q <= 2'd2; end
            default: begin e0_q <= e1_q; e1_q <= push_data; ovf_q <= 1'b1; end
          endcase
        end
        2'b01: begin
          ovf_q <= 1'b0;
          if (cnt_q == 2'd1) cnt_q <= 2'd0;
          else begin e0_q <= e1_q; cnt_q <= 2'd1; end
        end
        2'b11: begin
          ovf_q <= 1'b0;
          if (cnt_q == 2'd1) e0_q <= push_data;
          else begin e0_q <= e1_q; e1_q <= push_data; end
        end
        default: ;
      endcase
    end
  end

  assign head = (cnt_q != 2'd0) ? e0_q : '0;
  assign cnt  = cnt_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  ch_ctrl_t      ctrl,
  input  logic [TW-1:0] timer_val,
  input  logic          pop,
  input  logic          flush,
  input  logic          flag_clr,
  output logic [TW-1:0] head,
  output logic [1:0]    fill,
  output logic          flag,
  output logic          evt
);
  logic rise, fall;
  logic [1:0] cnt;
  logic ovf;
  logic flag_q;

  cap_sync_qual u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .rise (rise),
    .fall (fall)
  );

  assign evt = ctrl.enable && edge_hit(ctrl.edge_sel, rise, fall);

  cap_fifo2 #(.W(TW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (evt),
    .push_data(timer_val),
    .pop      (pop),
    .flush    (flush),
    .head     (head),
    .cnt      (cnt),
    .ovf      (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (evt)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign fill = fill_code(cnt, ovf);
  assign flag = flag_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int TW     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            timer_val,
  input  logic [NUM_CH-1:0]        cap_pin,
  input  logic                     cfg_we,
  input  logic [NUM_CH*CTRL_W-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0]        rd_pop,
  input  logic [NUM_CH-1:0]        fifo_flush,
  input  logic [NUM_CH-1:0]        flag_clr,
  output logic [NUM_CH*TW-1:0]     rd_data,
  output logic [2*NUM_CH-1:0]      fill_lvl,
  output logic [NUM_CH-1:0]        cap_flag,
  output logic                     irq
);
  ch_ctrl_t          ctrl_q [NUM_CH];
  logic [NUM_CH-1:0] cap_evt;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_ien;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q[i] <= '0;
      else if (cfg_we) ctrl_q[i] <= ch_ctrl_t'(cfg_wdata[i*CTRL_W +: CTRL_W]);
    end

    assign ch_en[i]  = ctrl_q[i].enable;
    assign ch_ien[i] = ctrl_q[i].irq_en;

    cap_channel #(.TW(TW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_pin[i]),
      .ctrl     (ctrl_q[i]),
      .timer_val(timer_val),
      .pop      (rd_pop[i]),
      .flush    (fifo_flush[i]),
      .flag_clr (flag_clr[i]),
      .head     (rd_data[i*TW +: TW]),
      .fill     (fill_lvl[2*i +: 2]),
      .flag     (cap_flag[i]),
      .evt      (cap_evt[i])
    );
  end

  assign irq = |(cap_flag & ch_ien);
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int NUM_CH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    cap_evt,
  input logic [NUM_CH-1:0]    ch_en,
  input logic [NUM_CH-1:0]    rd_pop,
  input logic [NUM_CH-1:0]    fifo_flush,
  input logic [NUM_CH-1:0]    flag_clr,
  input logic [2*NUM_CH-1:0]  fill_lvl,
  input logic [NUM_CH-1:0]    cap_flag
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_capture_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |-> ch_en[i]);

    assert_flag_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> cap_flag[i]);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag[i] && !flag_clr[i]) |=> cap_flag[i]);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush[i] |=> (fill_lvl[2*i +: 2] == 2'd0));

    assert_overflow_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_lvl[2*i +: 2] == 2'd2 && cap_evt[i] && !rd_pop[i] && !fifo_flush[i])
      |=> (fill_lvl[2*i +: 2] == 2'd3));

    assert_fill_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_evt[i] && !rd_pop[i] && !fifo_flush[i]) |=> $stable(fill_lvl[2*i +: 2]));
  end
endmodule

bind cap_unit cap_unit_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_evt   (cap_evt),
  .ch_en     (ch_en),
  .rd_pop    (rd_pop),
  .fifo_flush(fifo_flush),
  .flag_clr  (flag_clr),
  .fill_lvl  (fill_lvl),
  .cap_flag  (cap_flag)
);

// File: tb/cap_unit_tb_top.sv
module cap_unit_tb_top;
  localparam int NCH = 3;
  localparam int TW  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [TW-1:0]     tmr = '0;
  logic [NCH-1:0]    cap_pin;
  logic              cfg_we;
  logic [NCH*4-1:0]  cfg_wdata;
  logic [NCH-1:0]    rd_pop, fifo_flush, flag_clr;
  logic [NCH*TW-1:0] rd_data;
  logic [2*NCH-1:0]  fill_lvl;
  logic [NCH-1:0]    cap_flag;
  logic              irq;

  always @(negedge clk) tmr <= tmr + 1'b1;

  cap_unit #(.NUM_CH(NCH), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .timer_val(tmr), .cap_pin(cap_pin),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_pop(rd_pop),
    .fifo_flush(fifo_flush), .flag_clr(flag_clr), .rd_data(rd_data),
    .fill_lvl(fill_lvl), .cap_flag(cap_flag), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0]    shadow [NCH];
  logic [TW-1:0] expq [NCH][$];
  bit            movf [NCH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [1:0] exp_fill(int ch);
    if (expq[ch].size() == 2 && movf[ch]) return 2'd3;
    return 2'(expq[ch].size());
  endfunction

  task automatic chk_fill(int ch, string tag);
    chk(tag, 32'(fill_lvl[2*ch +: 2]), 32'(exp_fill(ch)));
  endtask

  task automatic write_cfg(int ch, logic en, logic [1:0] sel, logic ien);
    shadow[ch] = {ien, sel, en};
    for (int i = 0; i < NCH; i++) cfg_wdata[4*i +: 4] = shadow[i];
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  // driver: change a pin and push the timestamp the requirements predict
  task automatic drive_pin(int ch, logic v);
    logic rise, fall;
    rise = v && !cap_pin[ch];
    fall = !v && cap_pin[ch];
    if (shadow[ch][0] && ((rise && shadow[ch][1]) || (fall && shadow[ch][2]))) begin
      if (expq[ch].size() == 2) begin
        void'(expq[ch].pop_front());
        movf[ch] = 1'b1;
      end
      expq[ch].push_back(tmr + 16'd3);
    end
    cap_pin[ch] = v;
  endtask

  // monitor: compare the oldest entry with the scoreboard, then pop it
  task automatic pop_chk(int ch, string tag);
    logic [TW-1:0] e;
    e = (expq[ch].size() != 0) ? expq[ch][0] : '0;
    chk(tag, 32'(rd_data[ch*TW +: TW]), 32'(e));
    rd_pop[ch] = 1'b1;
    tick(1);
    rd_pop[ch] = 1'b0;
    if (expq[ch].size() != 0) void'(expq[ch].pop_front());
    movf[ch] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cap_pin = '0; cfg_we = 1'b0; cfg_wdata = '0;
    rd_pop = '0; fifo_flush = '0; flag_clr = '0;
    for (int i = 0; i < NCH; i++) begin shadow[i] = '0; movf[i] = 1'b0; end
    tick(3);
    rst_n = 1'b1;
    tick(1);

    chk("R5 reset fill", 32'(fill_lvl), 32'd0);
    chk("R8 reset flags", 32'(cap_flag), 32'd0);
    chk("R9 reset irq", 32'(irq), 32'd0);
    chk("R4 reset rd_data", 32'(rd_data[TW-1:0]), 32'd0);

    write_cfg(0, 1'b1, 2'b01, 1'b1);
    drive_pin(0, 1'b1);
    tick(3);
    chk("R1 not before fourth edge", 32'(fill_lvl[1:0]), 32'd0);
    tick(1);
    chk_fill(0, "R1 capture after fourth edge");
    chk("R8 flag set", 32'(cap_flag[0]), 32'd1);
    chk("R9 irq enabled", 32'(irq), 32'd1);

    drive_pin(0, 1'b0); tick(4);
    chk_fill(0, "R2 falling ignored in rising mode");

    cap_pin[0] = 1'b1; tick(1); cap_pin[0] = 1'b0; tick(4);
    chk_fill(0, "R1 one-cycle pulse ignored");

    drive_pin(0, 1'b1); tick(2); drive_pin(0, 1'b0); tick(4);
    chk_fill(0, "R1 two-cycle pulse captured");

    drive_pin(0, 1'b1); tick(4);
    chk_fill(0, "R5 overflow code");
    drive_pin(0, 1'b0); tick(4);
    pop_chk(0, "R5 oldest discarded R3");
    chk_fill(0, "R6 pop from overflow");
    pop_chk(0, "R3 timestamp R4");
    chk_fill(0, "R4 empty after pops");
    pop_chk(0, "R4 empty reads zero");
    chk_fill(0, "R4 pop on empty");

    flag_clr[0] = 1'b1; tick(1); flag_clr[0] = 1'b0;
    chk("R8 write-one clear", 32'(cap_flag[0]), 32'd0);
    chk("R9 irq drops", 32'(irq), 32'd0);

    write_cfg(1, 1'b1, 2'b10, 1'b0);
    drive_pin(1, 1'b1); tick(4);
    chk_fill(1, "R2 rising ignored in falling mode");
    drive_pin(1, 1'b0); tick(4);
    chk_fill(1, "R2 falling captured");
    chk("R8 flag ch1", 32'(cap_flag[1]), 32'd1);
    chk("R9 masked flag no irq", 32'(irq), 32'd0);
    chk_fill(0, "R11 ch0 untouched");
    chk("R11 ch0 flag untouched", 32'(cap_flag[0]), 32'd0);

    write_cfg(2, 1'b1, 2'b11, 1'b1);
    drive_pin(2, 1'b1); tick(4);
    drive_pin(2, 1'b0); tick(4);
    chk_fill(2, "R2 both edges captured");
    chk("R9 irq from ch2", 32'(irq), 32'd1);

    write_cfg(2, 1'b0, 2'b11, 1'b1);
    drive_pin(2, 1'b1); tick(4);
    drive_pin(2, 1'b0); tick(4);
    chk_fill(2, "R10 disabled ignores edges");
    pop_chk(2, "R10 data kept R3");
    pop_chk(2, "R10 second entry");

    fifo_flush[1] = 1'b1; tick(1); fifo_flush[1] = 1'b0;
    expq[1].delete(); movf[1] = 1'b0;
    chk_fill(1, "R7 flush empties");
    chk("R7 flushed reads zero", 32'(rd_data[TW +: TW]), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule